// File: doc/BRIEF.md
# Sleep and Interrupt Wake-Up Controller

This block sequences the power-down of a small 8-bit processor core. The core raises a one-cycle strobe when it executes its sleep instruction. The controller then decides, from the interrupt state, whether the instruction is a real power-down or is dropped as a no-operation. On a real power-down it holds the core clock, pulses a clear to the watchdog and its prescaler, and updates the two status bits that software reads afterwards: time-out (TO) and power-down (PD). It holds the core until an interrupt source that is both flagged and enabled appears. This happens whether or not the global interrupt enable is set.

On wake-up, the crystal-type oscillator modes keep the core held while an oscillator start-up counter runs its full count. The internal oscillator mode releases the core at once. When the core is released with global interrupts enabled, the controller raises a one-cycle request that tells the core to vector to its interrupt handler. Otherwise the core continues in-line. Software tells a dropped sleep from a real one by reading PD: it is still 1 after a dropped sleep.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, TO and PD are both 1, core_hold is 0, wdt_clear and vector_req are 0, and osc_ready is 1.
- R2: A wake source is any index i where irq_flag[i] and irq_enable[i] are both 1. A set flag whose enable is 0, or a set enable whose flag is 0, does not wake the block. Waking does not depend on global_ie.
- R3: If a wake source was present in the cycle before the sleep strobe, the strobe is a no-operation. core_hold stays 0, there is no wdt_clear pulse, and TO and PD keep their values.
- R4: If no wake source was present in the cycle before the strobe, then in the cycle after the strobe core_hold is 1, TO is 1, PD is 0, and wdt_clear is 1. wdt_clear lasts exactly one cycle.
- R5: A wake source that first appears in the strobe cycle counts as arriving during the sleep. The block performs the full power-down and starts waking in the next cycle, even if the source has dropped by then.
- R6: While sleeping with no wake source, core_hold stays 1.
- R7: osc_mode codes 0, 1 and 2 (low-power crystal, crystal, high-speed crystal) keep core_hold at 1 for exactly OST_CYCLES cycles after the clock edge that detects the wake. osc_ready is 0 from power-down entry until the core is released.
- R8: osc_mode code 3 (internal oscillator) skips the start-up count. core_hold falls in the cycle right after the edge that detects the wake.
- R9: vector_req is a one-cycle pulse in the first cycle after release, and only if global_ie was 1 at the release edge. Otherwise it stays 0.
- R10: A sleep strobe that arrives while the core is held is ignored. It produces no wdt_clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_exec | input | 1 | One-cycle strobe: the sleep instruction executes |
| irq_flag | input | NUM_SRC | Interrupt flag bits |
| irq_enable | input | NUM_SRC | Interrupt enable bits |
| global_ie | input | 1 | Global interrupt enable |
| osc_mode | input | 2 | Oscillator mode: 0 LP, 1 XT, 2 HS, 3 internal |
| core_hold | output | 1 | Stops the core clock while high |
| wdt_clear | output | 1 | One-cycle clear for the watchdog and its prescaler |
| to_bit | output | 1 | Time-out status bit |
| pd_bit | output | 1 | Power-down status bit |
| vector_req | output | 1 | Request to call the interrupt handler |
| osc_ready | output | 1 | Start-up count finished or skipped |

## Verification
The bench builds the block with NUM_SRC = 4 and OST_CYCLES = 8. The short count lets it measure the exact hold length after every wake, across all four oscillator codes and both global enable values, on every source index. With four sources, it can apply every lone-flag and lone-enable pattern on each index during sleep. It also drives both race timings, a source set one cycle before the strobe and a source set in the strobe cycle, on a freshly reset block, so that TO and PD show which path was taken.

// File: rtl/swk_pkg.sv
package swk_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_OSTWAIT = 2'd2
    } pwr_state_e;

    typedef enum logic [1:0] {
        OSC_LP    = 2'd0,
        OSC_XT    = 2'd1,
        OSC_HS    = 2'd2,
        OSC_INTRC = 2'd3
    } osc_mode_e;

    typedef struct packed {
        logic to;
        logic pd;
    } pwr_status_t;

    localparam pwr_status_t STATUS_RESET = '{to: 1'b1, pd: 1'b1};

    function automatic logic osc_needs_ost(input logic [1:0] mode);
        return mode != OSC_INTRC;
    endfunction

endpackage

// File: rtl/swk_wake_detect.sv
module swk_wake_detect #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] flag_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic               any_o,
    output logic               prior_o
);
    logic [NUM_SRC-1:0] hit;
    logic               prior_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = flag_i[i] & en_i[i];
    end

    assign any_o   = |hit;
    assign prior_o = prior_q;

    always_ff @(posedge clk) begin
        if (rst) prior_q <= 1'b0;
        else     prior_q <= any_o;
    end

    // R2
    prior_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_i == '0) |=> !prior_o);

endmodule

// File: rtl/swk_ost_timer.sv
module swk_ost_timer #(
    parameter int OST_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (OST_CYCLES > 2) ? $clog2(OST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OST_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i)  cnt_q <= '0;
        else if (tick_o)   cnt_q <= '0;
        else if (run_i)    cnt_q <= cnt_q + 1'b1;
    end

    // R7
    ost_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0));

    // R7
    ost_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && !clr_i && !tick_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/swk_seq.sv
module swk_seq
    import swk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_exec_i,
    input  logic       wake_any_i,
    input  logic       wake_prior_i,
    input  logic       gie_i,
    input  logic [1:0] osc_mode_i,
    input  logic       ost_tick_i,
    output logic       ost_clr_o,
    output logic       ost_run_o,
    output logic       hold_o,
    output logic       wdt_clr_o,
    output logic       to_o,
    output logic       pd_o,
    output logic       vector_o,
    output logic       ost_done_o
);
    pwr_state_e  state_q, state_d;
    pwr_status_t stat_q;
    logic        early_q, wdt_clr_q, vector_q, ost_done_q;
    logic        in_run, enter, wake_now, leave;

    assign in_run   = (state_q == ST_RUN);
    assign enter    = in_run && sleep_exec_i && !wake_prior_i;
    assign wake_now = (state_q == ST_SLEEP) && (wake_any_i || early_q);
    assign leave    = (wake_now && !osc_needs_ost(osc_mode_i))
                   || ((state_q == ST_OSTWAIT) && ost_tick_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (enter) state_d = ST_SLEEP;
            ST_SLEEP:   if (wake_now)
                            state_d = osc_needs_ost(osc_mode_i) ? ST_OSTWAIT : ST_RUN;
            ST_OSTWAIT: if (ost_tick_i) state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RUN;
            stat_q     <= STATUS_RESET;
            early_q    <= 1'b0;
            wdt_clr_q  <= 1'b0;
            vector_q   <= 1'b0;
            ost_done_q <= 1'b1;
        end else begin
            state_q   <= state_d;
            wdt_clr_q <= enter;
            vector_q  <= leave && gie_i;
            if (enter) begin
                stat_q.to  <= 1'b1;
                stat_q.pd  <= 1'b0;
                early_q    <= wake_any_i;
                ost_done_q <= 1'b0;
            end else begin
                if (wake_now) early_q    <= 1'b0;
                if (leave)    ost_done_q <= 1'b1;
            end
        end
    end

    assign ost_clr_o  = enter;
    assign ost_run_o  = (state_q == ST_OSTWAIT);
    assign hold_o     = !in_run;
    assign wdt_clr_o  = wdt_clr_q;
    assign to_o       = stat_q.to;
    assign pd_o       = stat_q.pd;
    assign vector_o   = vector_q;
    assign ost_done_o = ost_done_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (in_run && stat_q.to && stat_q.pd && !wdt_clr_q && !vector_q));

    // R3
    nop_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && sleep_exec_i && wake_prior_i) |=> (in_run && !wdt_clr_q && $stable(stat_q)));

    // R4
    full_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && sleep_exec_i && !wake_prior_i) |=> (hold_o && wdt_clr_q && stat_q.to && !stat_q.pd));

    // R4
    wdt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_clr_q |=> !wdt_clr_q);

    // R5
    early_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && sleep_exec_i && !wake_prior_i && wake_any_i) |=> ##1 (state_q != ST_SLEEP));

    // R6
    stay_asleep_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_SLEEP) && !wake_any_i && !early_q) |=> (state_q == ST_SLEEP));

    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_SLEEP) && wake_any_i && (osc_mode_i == 2'd3)) |=> !hold_o);

    // R9
    vector_gie_chk: assert property (@(posedge clk) disable iff (rst)
        vector_q |-> ($past(gie_i) && in_run && $past(hold_o)));

    // R10
    ignore_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_run && sleep_exec_i) |=> !wdt_clr_q);

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
    parameter int NUM_SRC    = 8,
    parameter int OST_CYCLES = 1024
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep_exec,
    input  logic [NUM_SRC-1:0] irq_flag,
    input  logic [NUM_SRC-1:0] irq_enable,
    input  logic               global_ie,
    input  logic [1:0]         osc_mode,
    output logic               core_hold,
    output logic               wdt_clear,
    output logic               to_bit,
    output logic               pd_bit,
    output logic               vector_req,
    output logic               osc_ready
);
    logic wake_any, wake_prior, ost_clr, ost_run, ost_tick;

    swk_wake_detect #(.NUM_SRC(NUM_SRC)) wake_i (
        .clk     (clk),
        .rst     (rst),
        .flag_i  (irq_flag),
        .en_i    (irq_enable),
        .any_o   (wake_any),
        .prior_o (wake_prior)
    );

    swk_ost_timer #(.OST_CYCLES(OST_CYCLES)) ost_i (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (ost_clr),
        .run_i  (ost_run),
        .tick_o (ost_tick)
    );

    swk_seq seq_i (
        .clk          (clk),
        .rst          (rst),
        .sleep_exec_i (sleep_exec),
        .wake_any_i   (wake_any),
        .wake_prior_i (wake_prior),
        .gie_i        (global_ie),
        .osc_mode_i   (osc_mode),
        .ost_tick_i   (ost_tick),
        .ost_clr_o    (ost_clr),
        .ost_run_o    (ost_run),
        .hold_o       (core_hold),
        .wdt_clr_o    (wdt_clear),
        .to_o         (to_bit),
        .pd_o         (pd_bit),
        .vector_o     (vector_req),
        .ost_done_o   (osc_ready)
    );

endmodule

// File: tb/sleep_wake_ctrl_tb.sv
module sleep_wake_ctrl_tb_top;
    localparam int N   = 4;
    localparam int OST = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sleep_exec = 1'b0;
    logic [N-1:0] irq_flag = '0;
    logic [N-1:0] irq_enable = '0;
    logic         global_ie = 1'b0;
    logic [1:0]   osc_mode = 2'd0;
    logic core_hold, wdt_clear, to_bit, pd_bit, vector_req, osc_ready;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sleep_wake_ctrl #(.NUM_SRC(N), .OST_CYCLES(OST)) dut_i (
        .clk(clk), .rst(rst), .sleep_exec(sleep_exec), .irq_flag(irq_flag),
        .irq_enable(irq_enable), .global_ie(global_ie), .osc_mode(osc_mode),
        .core_hold(core_hold), .wdt_clear(wdt_clear), .to_bit(to_bit),
        .pd_bit(pd_bit), .vector_req(vector_req), .osc_ready(osc_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sleep_exec = 1'b0; irq_flag = '0; irq_enable = '0;
        step(); step();
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    // Full sleep then wake on source src, in the given oscillator mode and global_ie value
    task automatic sleep_wake(input int mode, input bit gie, input int src);
        int held;
        do_reset();
        @(negedge clk);
        osc_mode = 2'(mode); global_ie = gie;
        irq_enable = '0; irq_enable[src] = 1'b1;
        sleep_exec = 1'b1;
        step();
        chk("R4 hold", core_hold, 1);
        chk("R4 wdt_clear", wdt_clear, 1);
        chk("R4 to", to_bit, 1);
        chk("R4 pd", pd_bit, 0);
        chk("R7 osc_ready low", osc_ready, 0);
        @(negedge clk);
        sleep_exec = 1'b0;
        step();
        chk("R4 wdt pulse ends", wdt_clear, 0);
        // strobe while held is ignored
        @(negedge clk);
        sleep_exec = 1'b1;
        step();
        @(negedge clk);
        sleep_exec = 1'b0;
        chk("R10 no wdt_clear", wdt_clear, 0);
        // lone flags on disabled sources, lone enable on src
        irq_flag = ~irq_enable;
        step(); step();
        chk("R2 lone flag no wake", core_hold, 1);
        @(negedge clk);
        irq_flag = '0; irq_enable = '1;
        step(); step();
        chk("R6 still asleep", core_hold, 1);
        chk("R2 lone enable no wake", vector_req, 0);
        @(negedge clk);
        irq_enable = '0; irq_enable[src] = 1'b1;
        irq_flag[src] = 1'b1;
        held = 0;
        for (int k = 0; k < OST + 4; k++) begin
            step();
            if (!core_hold) break;
            held++;
        end
        if (mode < 3) chk("R7 start-up hold cycles", held, OST);
        else          chk("R8 bypass hold cycles", held, 0);
        chk("R9 vector_req on release", vector_req, int'(gie));
        chk("R7 osc_ready at release", osc_ready, 1);
        step();
        chk("R9 vector_req one cycle", vector_req, 0);
        @(negedge clk);
        irq_flag = '0;
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 to", to_bit, 1);
        chk("R1 pd", pd_bit, 1);
        chk("R1 hold", core_hold, 0);
        chk("R1 wdt_clear", wdt_clear, 0);
        chk("R1 vector_req", vector_req, 0);
        chk("R1 osc_ready", osc_ready, 1);

        for (int m = 0; m < 4; m++)
            for (int g = 0; g < 2; g++)
                for (int s = 0; s < N; s++)
                    sleep_wake(m, g[0], s);

        // R3: source pending one cycle before the strobe
        for (int s = 0; s < N; s++) begin
            do_reset();
            @(negedge clk);
            irq_enable[s] = 1'b1; irq_flag[s] = 1'b1;
            @(negedge clk);
            sleep_exec = 1'b1;
            step();
            chk("R3 hold stays low", core_hold, 0);
            chk("R3 no wdt_clear", wdt_clear, 0);
            chk("R3 pd unchanged", pd_bit, 1);
            chk("R3 to unchanged", to_bit, 1);
            @(negedge clk);
            sleep_exec = 1'b0;
        end

        // R5: source appears in the strobe cycle, then drops
        for (int m = 0; m < 4; m++) begin
            int held;
            do_reset();
            @(negedge clk);
            osc_mode = 2'(m); global_ie = 1'b1;
            irq_enable[1] = 1'b1; irq_flag[1] = 1'b1; sleep_exec = 1'b1;
            step();
            chk("R5 full sleep pd", pd_bit, 0);
            chk("R5 hold", core_hold, 1);
            @(negedge clk);
            sleep_exec = 1'b0; irq_flag = '0;
            step();
            held = 0;
            for (int k = 0; k < OST + 4; k++) begin
                if (!core_hold) break;
                held++;
                step();
            end
            chk("R5 wakes after dropped source", held, (m < 3) ? OST : 0);
            chk("R5 vector_req", vector_req, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule